// File: doc/BRIEF.md
# Host Packet Request/Completion Splitter

This block takes the receive stream from a host link and splits it by packet kind. Host-issued reads and writes that hit one of the device's memory regions go to a request output. Completions that answer reads the device issued go to a completion output. Any other packet is taken off the input and thrown away. That covers requests that hit no region, including unsolicited broadcasts from the host chipset, and packets of an unknown kind. Each packet is a run of beats marked with start and end flags. All three streams use a valid/ready handshake.

The routing decision is made on the first beat of a packet and kept until the last beat has been accepted. Data passes through with no added latency. When the chosen output is not ready, the input stalls. A full consumer never causes a packet to be lost. A saturating counter reports how many packets have been discarded.

Top module: `hostpkt_splitter`

## Requirements
- R1: The kind of a packet is read from bits [TYPE_LSB+1:TYPE_LSB] of its first beat (bits 31:30 by default). Code 00 is a write and 01 is a read. A write or read whose region-hit vector has at least one bit set is routed to the request output.
- R2: A packet of kind 10 (completion) is routed to the completion output whatever the region-hit vector holds.
- R3: A write or read whose region-hit vector is all zero is dropped whole: no beat of it raises either output valid.
- R4: A packet of kind 11 is dropped whole, whatever its hit vector.
- R5: While a dropped packet is being consumed, in_ready is high on every beat up to and including its last.
- R6: For a routed packet, in_ready equals the ready of the chosen output. While that output is not ready, the beat is held and stays valid on the output, and nothing is discarded.
- R7: The route chosen on the first beat is kept for every later beat of the packet, even if the kind bits or the hit vector change on those beats. The next decision is taken on the beat after the last beat.
- R8: drop_count rises by one in the cycle after the first beat of a dropped packet is accepted. It saturates at 2^CNT_W-1.
- R9: After reset, drop_count is zero and the first valid beat is treated as the start of a packet.
- R10: On a routed beat, data, start flag and end flag appear unchanged on the chosen output in the same cycle. The other output's valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DATA_W | Beat payload, carrying the kind field on the first beat |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Last beat of packet |
| in_region_hit | input | REGION_N | One bit per owned memory region |
| req_valid | output | 1 | Request output valid |
| req_ready | input | 1 | Request consumer ready |
| req_data | output | DATA_W | Request beat payload |
| req_sop | output | 1 | Request first beat |
| req_eop | output | 1 | Request last beat |
| cpl_valid | output | 1 | Completion output valid |
| cpl_ready | input | 1 | Completion consumer ready |
| cpl_data | output | DATA_W | Completion beat payload |
| cpl_sop | output | 1 | Completion first beat |
| cpl_eop | output | 1 | Completion last beat |
| drop_count | output | CNT_W | Saturating count of discarded packets |

## Verification
The hardest case to reach is a multi-beat packet whose later beats carry kind bits and hit vectors that would, on their own, select a different route. This has to happen while the chosen consumer keeps withdrawing ready, so that the held route has to survive many stalled cycles. The stimulus scrambles the header field and hit vector on every non-first beat and drops each consumer's ready at random. Directed packets also hold ready low for several cycles in a row. Counter saturation is reached by building the bench with a narrow counter and sending a burst of dropped packets.

// File: rtl/hps_pkg.sv
package hps_pkg;
  typedef enum logic [1:0] {
    RT_REQ  = 2'd0,
    RT_CPL  = 2'd1,
    RT_DROP = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    PK_WR    = 2'b00,
    PK_RD    = 2'b01,
    PK_CPL   = 2'b10,
    PK_OTHER = 2'b11
  } pkind_e;
endpackage

// File: rtl/hps_classify.sv
module hps_classify
  import hps_pkg::*;
#(
  parameter int REGION_N = 4
) (
  input  logic [1:0]          kind,
  input  logic [REGION_N-1:0] hit,
  output route_e              route
);
  logic any_hit;

  always_comb begin
    any_hit = |hit;
    unique case (pkind_e'(kind))
      PK_WR, PK_RD: route = any_hit ? RT_REQ : RT_DROP;
      PK_CPL:       route = RT_CPL;
      default:      route = RT_DROP;
    endcase
  end
endmodule

// File: rtl/hps_route_hold.sv
module hps_route_hold
  import hps_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  route_e first_route,
  input  logic   xfer,
  input  logic   eop,
  output route_e cur_route,
  output logic   in_pkt
);
  logic   in_pkt_q, in_pkt_d;
  route_e held_q, held_d;
  logic   en;

  always_comb begin
    cur_route = in_pkt_q ? held_q : first_route;
    en        = xfer;
    in_pkt_d  = !eop;
    held_d    = cur_route;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      held_q   <= RT_DROP;
    end else if (en) begin
      in_pkt_q <= in_pkt_d;
      held_q   <= held_d;
    end
  end

  assign in_pkt = in_pkt_q;

  AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !eop) |=> (cur_route == $past(cur_route))); // R7

  AST_NEW_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && eop) |=> !in_pkt); // R7
endmodule

// File: rtl/hps_drop_count.sv
module hps_drop_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    en    = inc && (cnt_q != CNT_MAX);
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R8
endmodule

// File: rtl/hostpkt_splitter.sv
module hostpkt_splitter
  import hps_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TYPE_LSB = 30,
  parameter int REGION_N = 4,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                in_sop,
  input  logic                in_eop,
  input  logic [REGION_N-1:0] in_region_hit,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [DATA_W-1:0]   req_data,
  output logic                req_sop,
  output logic                req_eop,
  output logic                cpl_valid,
  input  logic                cpl_ready,
  output logic [DATA_W-1:0]   cpl_data,
  output logic                cpl_sop,
  output logic                cpl_eop,
  output logic [CNT_W-1:0]    drop_count
);
  route_e first_route, route;
  logic   in_pkt, xfer, drop_inc;

  hps_classify #(.REGION_N(REGION_N)) u_classify (
    .kind  (in_data[TYPE_LSB +: 2]),
    .hit   (in_region_hit),
    .route (first_route)
  );

  hps_route_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .first_route (first_route),
    .xfer        (xfer),
    .eop         (in_eop),
    .cur_route   (route),
    .in_pkt      (in_pkt)
  );

  always_comb begin
    unique case (route)
      RT_REQ:  in_ready = req_ready;
      RT_CPL:  in_ready = cpl_ready;
      default: in_ready = 1'b1;
    endcase
    xfer      = in_valid && in_ready;
    drop_inc  = xfer && !in_pkt && (route == RT_DROP);
    req_valid = in_valid && (route == RT_REQ);
    cpl_valid = in_valid && (route == RT_CPL);
    req_data  = in_data;
    req_sop   = in_sop;
    req_eop   = in_eop;
    cpl_data  = in_data;
    cpl_sop   = in_sop;
    cpl_eop   = in_eop;
  end

  hps_drop_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (drop_inc),
    .cnt   (drop_count)
  );

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && cpl_valid)); // R10

  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> ((req_valid && !req_ready) || (cpl_valid && !cpl_ready))); // R6

  AST_DROP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !req_valid && !cpl_valid) |-> in_ready); // R5

  AST_ROUTED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid || cpl_valid) |-> (in_ready == (req_valid ? req_ready : cpl_ready))); // R6
endmodule

// File: tb/hostpkt_splitter_tb_top.sv
module hostpkt_splitter_tb_top;
  localparam int DW = 32;
  localparam int RN = 4;
  localparam int CW = 4;
  localparam int TL = 30;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_sop, in_eop;
  logic [DW-1:0] in_data;
  logic [RN-1:0] in_region_hit;
  logic req_valid, req_ready, req_sop, req_eop;
  logic [DW-1:0] req_data;
  logic cpl_valid, cpl_ready, cpl_sop, cpl_eop;
  logic [DW-1:0] cpl_data;
  logic [CW-1:0] drop_count;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  int rdy_pct = 70;
  bit finished = 0;

  always #4 clk = ~clk;

  hostpkt_splitter #(.DATA_W(DW), .TYPE_LSB(TL), .REGION_N(RN), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_region_hit(in_region_hit),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_sop(req_sop), .req_eop(req_eop),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_data(cpl_data),
    .cpl_sop(cpl_sop), .cpl_eop(cpl_eop),
    .drop_count(drop_count)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // route codes: 0 request, 1 completion, 2 drop
  function automatic int exp_route(logic [1:0] kind, logic [RN-1:0] hit);
    if (kind == 2'b10) return 1;
    if (kind == 2'b11) return 2;
    return (hit != 0) ? 0 : 2;
  endfunction

  function automatic string route_tag(int r, logic [1:0] kind);
    if (r == 0) return "R1";
    if (r == 1) return "R2";
    return (kind == 2'b11) ? "R4" : "R3";
  endfunction

  task automatic check_beat(int r, string tag, bit mid);
    logic exp_rdy;
    string t;
    t = mid ? "R7" : tag;
    exp_rdy = (r == 0) ? req_ready : (r == 1) ? cpl_ready : 1'b1;
    check(req_valid == (r == 0), t, req_valid, r == 0);
    check(cpl_valid == (r == 1), t, cpl_valid, r == 1);
    check(in_ready == exp_rdy, (r == 2) ? "R5" : "R6", in_ready, exp_rdy);
    if (r == 0)
      check(req_data == in_data && req_sop == in_sop && req_eop == in_eop,
            "R10", req_data, in_data);
    if (r == 1)
      check(cpl_data == in_data && cpl_sop == in_sop && cpl_eop == in_eop,
            "R10", cpl_data, in_data);
    check(drop_count == CW'(exp_cnt), "R8", drop_count, exp_cnt);
  endtask

  task automatic idle_cycle();
    in_valid = 1'b0;
    req_ready = ($urandom % 2) == 1;
    cpl_ready = ($urandom % 2) == 1;
    #2;
    check(!req_valid && !cpl_valid, "R10", {req_valid, cpl_valid}, 0);
    check(drop_count == CW'(exp_cnt), "R8", drop_count, exp_cnt);
    @(posedge clk); #1;
  endtask

  // stall_n: number of leading cycles with ready forced low on each beat
  task automatic send_pkt(logic [1:0] kind, logic [RN-1:0] hit, int len,
                          bit scramble, int stall_n);
    int r;
    string tag;
    r = exp_route(kind, hit);
    tag = route_tag(r, kind);
    for (int b = 0; b < len; b++) begin
      bit acc;
      int waits;
      logic [DW-1:0] d;
      d = $urandom;
      if (b == 0) d[TL +: 2] = kind;
      acc = 0;
      waits = 0;
      while (!acc) begin
        in_valid = 1'b1;
        in_data = d;
        in_sop = (b == 0);
        in_eop = (b == len - 1);
        in_region_hit = (b == 0 || !scramble) ? hit : RN'($urandom);
        if (b > 0 && scramble) in_data[TL +: 2] = 2'($urandom);
        if (waits < stall_n) begin
          req_ready = 1'b0;
          cpl_ready = 1'b0;
        end else begin
          req_ready = ($urandom % 100) < rdy_pct;
          cpl_ready = ($urandom % 100) < rdy_pct;
        end
        #2;
        check_beat(r, tag, b > 0 && scramble);
        acc = in_ready;
        waits++;
        @(posedge clk); #1;
        if (acc && b == 0 && r == 2 && exp_cnt < (1 << CW) - 1) exp_cnt++;
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0;
    in_region_hit = '0; req_ready = 1'b1; cpl_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(drop_count == 0, "R9", drop_count, 0);
    check(!req_valid && !cpl_valid, "R9", {req_valid, cpl_valid}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R9: first beat after reset starts a packet (write with hit)
    send_pkt(2'b00, 4'b0010, 3, 0, 0);
    // R6: long stall on request output
    send_pkt(2'b01, 4'b1000, 4, 0, 5);
    // R2: completion with no hit, stalled
    send_pkt(2'b10, 4'b0000, 3, 0, 3);
    // R3: request with no region hit (broadcast-like)
    send_pkt(2'b00, 4'b0000, 5, 0, 2);
    // R4: unknown kind with hits
    send_pkt(2'b11, 4'b1111, 2, 0, 0);
    // R7: header bits and hits scrambled mid packet, per route
    send_pkt(2'b00, 4'b0001, 6, 1, 2);
    send_pkt(2'b10, 4'b0000, 6, 1, 2);
    send_pkt(2'b01, 4'b0000, 6, 1, 0);
    idle_cycle();

    // random mix
    for (int p = 0; p < 400; p++) begin
      rdy_pct = 30 + ($urandom % 70);
      send_pkt(2'($urandom), RN'($urandom % 3 == 0 ? 0 : $urandom),
               1 + ($urandom % 6), ($urandom % 2) == 1, $urandom % 3);
      if ($urandom % 4 == 0) idle_cycle();
    end

    // R8: saturation of the narrow counter
    for (int p = 0; p < 20; p++) send_pkt(2'b11, 4'b0000, 1, 0, 0);
    idle_cycle();
    check(drop_count == {CW{1'b1}}, "R8", drop_count, {CW{1'b1}});

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule